// File: doc/BRIEF.md
# Stream Packet Header Framer and Checker

This block holds two independent stream paths that share one clock and reset. The framer path adds a header to a payload stream. A request handshake carries a stream ID, a packet type, a source row and a source column, plus a flag that marks a packet with no payload. The framer latches these fields and emits a single 32-bit header word with an odd-parity bit. It then passes the payload words through unchanged and keeps the payload's end-of-packet mark as TLAST.

The checker path receives a framed stream and treats the first word of each packet as the header. It verifies the parity and the mandatory zero fields, and it extracts the four fields into held outputs. The checker never drops a word. It forwards every word, marks the header word, tags every word of a damaged packet with an error flag, and raises a one-cycle error pulse for each damaged header. Both paths follow ready/valid rules under downstream backpressure.

Top module: `shdr_top`

## Requirements
- R1: The header word places the stream ID in bits 4:0, the packet type in bits 14:12, the source row in bits 20:16 and the source column in bits 27:21. Bits 30:28, bit 15 and bits 11:5 are zero.
- R2: Bit 31 of every header word is set so that the whole 32-bit word holds an odd number of ones.
- R3: After the header word, the framer forwards the payload words in order and unchanged. Its TLAST copies the payload's last flag, and the header word does not carry TLAST when a payload follows.
- R4: A request with the no-payload flag set produces a header word with TLAST set. No payload word is consumed for that request.
- R5: The framer latches the sideband fields when the request is accepted (request valid and ready high at a clock edge). Later changes to the fields do not alter the header word of that packet.
- R6: When framer output ready is low, the framer holds its output word and TLAST stable and drops or repeats no word. During payload transfer, payload ready follows output ready.
- R7: The checker marks the first word it accepts after reset, and the first word it accepts after each word with TLAST, as a header (is-header output high). All other words are marked as payload.
- R8: On accepting a header word, the checker loads the ID, type, row and column fields from the R1 positions into its field outputs. The outputs show the new values from the next cycle and hold them until the next header.
- R9: A header with even ones-count, or with any nonzero bit in 30:28, 15 or 11:5, causes an error pulse that is high for exactly the one cycle after that header is accepted.
- R10: Every word of a packet whose header failed R9 is still forwarded, with the error tag high. Words of a clean packet carry the tag low.
- R11: The checker forwards data, TLAST and valid unchanged, and its input ready equals its output ready. A word held under backpressure does not advance the packet state.
- R12: After reset, the framer request ready is high, framer output valid is low, the checker error pulse is low and the checker expects a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_req_valid | input | 1 | Header request valid |
| f_req_ready | output | 1 | Header request accepted |
| f_req_id | input | 5 | Stream ID for the header |
| f_req_type | input | 3 | Packet type for the header |
| f_req_row | input | 5 | Source row for the header |
| f_req_col | input | 7 | Source column for the header |
| f_req_empty | input | 1 | Packet has no payload |
| f_pl_valid | input | 1 | Payload word valid |
| f_pl_ready | output | 1 | Payload word accepted |
| f_pl_data | input | 32 | Payload word |
| f_pl_last | input | 1 | Last payload word |
| f_out_valid | output | 1 | Framed word valid |
| f_out_ready | input | 1 | Framed word accepted downstream |
| f_out_data | output | 32 | Framed word |
| f_out_last | output | 1 | Framed TLAST |
| k_in_valid | input | 1 | Checker input valid |
| k_in_ready | output | 1 | Checker input accepted |
| k_in_data | input | 32 | Checker input word |
| k_in_last | input | 1 | Checker input TLAST |
| k_out_valid | output | 1 | Checker output valid |
| k_out_ready | input | 1 | Checker output accepted downstream |
| k_out_data | output | 32 | Checker output word |
| k_out_last | output | 1 | Checker output TLAST |
| k_out_is_hdr | output | 1 | Current word is a header |
| k_out_err | output | 1 | Current word belongs to a damaged packet |
| k_err_pulse | output | 1 | One-cycle pulse per damaged header |
| k_rx_id | output | 5 | Extracted stream ID |
| k_rx_type | output | 3 | Extracted packet type |
| k_rx_row | output | 5 | Extracted source row |
| k_rx_col | output | 7 | Extracted source column |

## Verification
In the checker, a header-only packet makes header detection and end-of-packet handling act on the same word. The next word must again be treated as a header, so that the R7 and R10 decisions overlap. The bench sends header-only packets, clean and damaged, back to back with other packets. It checks the is-header mark and the error tag on each word against the table. Backpressure on a header word that also has TLAST is covered as well: a stalled word must leave the packet state unchanged, and that state is checked through the is-header mark before and after the word is accepted.

// File: rtl/shdr_pkg.sv
package shdr_pkg;
  localparam int WORD_W   = 32;
  localparam int ID_W     = 5;
  localparam int TYPE_W   = 3;
  localparam int ROW_W    = 5;
  localparam int COL_W    = 7;
  localparam int ID_LSB   = 0;
  localparam int TYPE_LSB = 12;
  localparam int ROW_LSB  = 16;
  localparam int COL_LSB  = 21;
  localparam int PAR_BIT  = WORD_W - 1;
  // zero-required bits: 30:28, 15, 11:5
  localparam logic [WORD_W-1:0] ZERO_MASK = 32'h7000_8FE0;

  typedef enum logic [1:0] {FR_IDLE, FR_HDR, FR_PAY} fr_state_e;

  function automatic logic [WORD_W-1:0] make_hdr(
    input logic [COL_W-1:0]  col,
    input logic [ROW_W-1:0]  row,
    input logic [TYPE_W-1:0] typ,
    input logic [ID_W-1:0]   id
  );
    logic [WORD_W-1:0] w;
    w = '0;
    w[COL_LSB  +: COL_W]  = col;
    w[ROW_LSB  +: ROW_W]  = row;
    w[TYPE_LSB +: TYPE_W] = typ;
    w[ID_LSB   +: ID_W]   = id;
    w[PAR_BIT] = ~^w[PAR_BIT-1:0];
    return w;
  endfunction

  function automatic logic hdr_bad(input logic [WORD_W-1:0] w);
    return (~^w) | (|(w & ZERO_MASK));
  endfunction
endpackage

// File: rtl/shdr_rst_sync.sv
module shdr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/shdr_framer.sv
module shdr_framer
  import shdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_id,
  input  logic [TYPE_W-1:0] req_type,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_empty,
  input  logic              pl_valid,
  output logic              pl_ready,
  input  logic [WORD_W-1:0] pl_data,
  input  logic              pl_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last
);
  fr_state_e         state_q, state_d;
  logic [WORD_W-1:0] hdr_q;
  logic              empty_q;
  logic              load_en;

  // next state and outputs
  always_comb begin
    state_d   = state_q;
    req_ready = 1'b0;
    pl_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = hdr_q;
    out_last  = empty_q;
    load_en   = 1'b0;
    unique case (state_q)
      FR_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          load_en = 1'b1;
          state_d = FR_HDR;
        end
      end
      FR_HDR: begin
        out_valid = 1'b1;
        if (out_ready) state_d = empty_q ? FR_IDLE : FR_PAY;
      end
      FR_PAY: begin
        out_valid = pl_valid;
        out_data  = pl_data;
        out_last  = pl_last;
        pl_ready  = out_ready;
        if (pl_valid && out_ready && pl_last) state_d = FR_IDLE;
      end
      default: state_d = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FR_IDLE;
    else        state_q <= state_d;
  end

  // sideband latch, enabled only on request acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q   <= '0;
      empty_q <= 1'b0;
    end else if (load_en) begin
      hdr_q   <= make_hdr(req_col, req_row, req_type, req_id);
      empty_q <= req_empty;
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  p_odd_par_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && state_q == FR_HDR |-> (^out_data));
  p_no_pl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != FR_PAY |-> !pl_ready);
  p_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && state_q == FR_HDR |-> (out_data & ZERO_MASK) == '0);
endmodule

// File: rtl/shdr_checker.sv
module shdr_checker
  import shdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic              out_is_hdr,
  output logic              out_err,
  output logic              err_pulse,
  output logic [ID_W-1:0]   rx_id,
  output logic [TYPE_W-1:0] rx_type,
  output logic [ROW_W-1:0]  rx_row,
  output logic [COL_W-1:0]  rx_col
);
  logic in_pkt_q, in_pkt_d;
  logic pkt_err_q;
  logic pulse_d;
  logic accept, hdr_acc, bad;

  assign accept     = in_valid && out_ready;
  assign out_is_hdr = !in_pkt_q;
  assign hdr_acc    = accept && out_is_hdr;
  assign bad        = hdr_bad(in_data);

  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign out_data  = in_data;
  assign out_last  = in_last;
  assign out_err   = out_is_hdr ? bad : pkt_err_q;

  always_comb begin
    in_pkt_d = in_pkt_q;
    if (accept) in_pkt_d = !in_last;
    pulse_d = hdr_acc && bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q  <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      in_pkt_q  <= in_pkt_d;
      err_pulse <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_err_q <= 1'b0;
      rx_id     <= '0;
      rx_type   <= '0;
      rx_row    <= '0;
      rx_col    <= '0;
    end else if (hdr_acc) begin
      pkt_err_q <= bad;
      rx_id     <= in_data[ID_LSB   +: ID_W];
      rx_type   <= in_data[TYPE_LSB +: TYPE_W];
      rx_row    <= in_data[ROW_LSB  +: ROW_W];
      rx_col    <= in_data[COL_LSB  +: COL_W];
    end
  end

  p_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_last |=> out_is_hdr);
  p_pulse_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(hdr_acc));
  p_tag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse && out_valid && !out_is_hdr |-> out_err);
  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !out_ready |=> $stable(out_is_hdr));
endmodule

// File: rtl/shdr_top.sv
module shdr_top
  import shdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              f_req_valid,
  output logic              f_req_ready,
  input  logic [ID_W-1:0]   f_req_id,
  input  logic [TYPE_W-1:0] f_req_type,
  input  logic [ROW_W-1:0]  f_req_row,
  input  logic [COL_W-1:0]  f_req_col,
  input  logic              f_req_empty,
  input  logic              f_pl_valid,
  output logic              f_pl_ready,
  input  logic [WORD_W-1:0] f_pl_data,
  input  logic              f_pl_last,
  output logic              f_out_valid,
  input  logic              f_out_ready,
  output logic [WORD_W-1:0] f_out_data,
  output logic              f_out_last,
  input  logic              k_in_valid,
  output logic              k_in_ready,
  input  logic [WORD_W-1:0] k_in_data,
  input  logic              k_in_last,
  output logic              k_out_valid,
  input  logic              k_out_ready,
  output logic [WORD_W-1:0] k_out_data,
  output logic              k_out_last,
  output logic              k_out_is_hdr,
  output logic              k_out_err,
  output logic              k_err_pulse,
  output logic [ID_W-1:0]   k_rx_id,
  output logic [TYPE_W-1:0] k_rx_type,
  output logic [ROW_W-1:0]  k_rx_row,
  output logic [COL_W-1:0]  k_rx_col
);
  logic rst_ns;

  shdr_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  shdr_framer framer_i (
    .clk(clk), .rst_n(rst_ns),
    .req_valid(f_req_valid), .req_ready(f_req_ready),
    .req_id(f_req_id), .req_type(f_req_type),
    .req_row(f_req_row), .req_col(f_req_col), .req_empty(f_req_empty),
    .pl_valid(f_pl_valid), .pl_ready(f_pl_ready),
    .pl_data(f_pl_data), .pl_last(f_pl_last),
    .out_valid(f_out_valid), .out_ready(f_out_ready),
    .out_data(f_out_data), .out_last(f_out_last)
  );

  shdr_checker checker_i (
    .clk(clk), .rst_n(rst_ns),
    .in_valid(k_in_valid), .in_ready(k_in_ready),
    .in_data(k_in_data), .in_last(k_in_last),
    .out_valid(k_out_valid), .out_ready(k_out_ready),
    .out_data(k_out_data), .out_last(k_out_last),
    .out_is_hdr(k_out_is_hdr), .out_err(k_out_err),
    .err_pulse(k_err_pulse),
    .rx_id(k_rx_id), .rx_type(k_rx_type),
    .rx_row(k_rx_row), .rx_col(k_rx_col)
  );
endmodule

// File: tb/shdr_top_tb_top.sv
module shdr_top_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 12;
  localparam int  WDOG_CYCLES = 5000;

  // {last, exp_hdr, exp_err, data}
  localparam logic [34:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 1'b0, 32'h8062_1005},
    {1'b0, 1'b0, 1'b0, 32'hDEAD_BEEF},
    {1'b1, 1'b0, 1'b0, 32'h1234_5678},
    {1'b0, 1'b1, 1'b1, 32'h0062_1005},
    {1'b1, 1'b0, 1'b1, 32'hAAAA_5555},
    {1'b1, 1'b1, 1'b0, 32'h8FFF_701F},
    {1'b0, 1'b1, 1'b1, 32'h0062_9005},
    {1'b0, 1'b0, 1'b1, 32'h0000_0000},
    {1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF},
    {1'b1, 1'b1, 1'b1, 32'h0062_1025},
    {1'b0, 1'b1, 1'b0, 32'h8062_1005},
    {1'b1, 1'b0, 1'b0, 32'h0000_0001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        f_req_valid = 1'b0, f_req_empty = 1'b0;
  logic [4:0]  f_req_id = '0, f_req_row = '0;
  logic [2:0]  f_req_type = '0;
  logic [6:0]  f_req_col = '0;
  logic        f_pl_valid = 1'b0, f_pl_last = 1'b0, f_out_ready = 1'b0;
  logic [31:0] f_pl_data = '0;
  logic        k_in_valid = 1'b0, k_in_last = 1'b0, k_out_ready = 1'b0;
  logic [31:0] k_in_data = '0;
  logic        f_req_ready, f_pl_ready, f_out_valid, f_out_last;
  logic [31:0] f_out_data, k_out_data;
  logic        k_in_ready, k_out_valid, k_out_last, k_out_is_hdr, k_out_err, k_err_pulse;
  logic [4:0]  k_rx_id, k_rx_row;
  logic [2:0]  k_rx_type;
  logic [6:0]  k_rx_col;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shdr_top dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", WDOG_CYCLES, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic prev_bad;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) step();

    // R12 reset state
    @(negedge clk);
    eq("R12 req_ready", f_req_ready, 1);
    eq("R12 out_valid", f_out_valid, 0);
    eq("R12 err_pulse", k_err_pulse, 0);
    eq("R12 expects header", k_out_is_hdr, 1);

    // checker table walk: R7 R9 R10 R11
    k_out_ready = 1'b1;
    prev_bad = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      step();
      k_in_valid = 1'b1;
      k_in_last  = VEC[i][34];
      k_in_data  = VEC[i][31:0];
      @(negedge clk);
      eq($sformatf("R11 data v%0d", i), k_out_data, VEC[i][31:0]);
      eq($sformatf("R11 last v%0d", i), k_out_last, VEC[i][34]);
      eq($sformatf("R7 is_hdr v%0d", i), k_out_is_hdr, VEC[i][33]);
      eq($sformatf("R10 err tag v%0d", i), k_out_err, VEC[i][32]);
      eq($sformatf("R9 pulse v%0d", i), k_err_pulse, prev_bad);
      if (i == 6) begin
        eq("R8 id", k_rx_id, 5'h1F);
        eq("R8 type", k_rx_type, 3'h7);
        eq("R8 row", k_rx_row, 5'h1F);
        eq("R8 col", k_rx_col, 7'h7F);
      end
      prev_bad = VEC[i][33] && VEC[i][32];
    end
    step();
    k_in_valid = 1'b0;
    @(negedge clk);
    eq("R9 pulse single", k_err_pulse, 0);
    eq("R8 id hold", k_rx_id, 5'd5);
    eq("R8 type hold", k_rx_type, 3'd1);
    eq("R8 row hold", k_rx_row, 5'd2);
    eq("R8 col hold", k_rx_col, 7'd3);

    // R11 stall on a header-only word
    step();
    k_out_ready = 1'b0;
    k_in_valid = 1'b1; k_in_last = 1'b1; k_in_data = 32'h0062_1005;
    @(negedge clk);
    eq("R11 ready follows", k_in_ready, 0);
    eq("R11 valid passes", k_out_valid, 1);
    step();
    @(negedge clk);
    eq("R11 stall keeps hdr", k_out_is_hdr, 1);
    eq("R9 no pulse on stall", k_err_pulse, 0);
    k_out_ready = 1'b1;
    step();
    k_in_last = 1'b0; k_in_data = 32'h8062_1005;
    @(negedge clk);
    eq("R9 pulse after stall", k_err_pulse, 1);
    eq("R7 hdr after last", k_out_is_hdr, 1);
    step();
    k_in_data = 32'h5555_0000;
    @(negedge clk);
    eq("R7 payload mark", k_out_is_hdr, 0);
    eq("R10 clean tag", k_out_err, 0);
    step();
    k_in_valid = 1'b0;

    // framer: packet with payload, R1 R3 R5 R6
    f_req_valid = 1'b1; f_req_empty = 1'b0;
    f_req_col = 7'd3; f_req_row = 5'd2; f_req_type = 3'd1; f_req_id = 5'd5;
    @(negedge clk);
    eq("R12 idle out_valid", f_out_valid, 0);
    step();
    f_req_valid = 1'b0;
    f_req_col = 7'h55; f_req_row = 5'h0A; f_req_type = 3'd6; f_req_id = 5'h15;
    @(negedge clk);
    eq("R1 header word", f_out_data, 32'h8062_1005);
    eq("R3 header no last", f_out_last, 0);
    eq("R6 pl_ready while header", f_pl_ready, 0);
    step();
    f_out_ready = 1'b1;
    @(negedge clk);
    eq("R5 R6 header held", f_out_data, 32'h8062_1005);
    eq("R6 valid held", f_out_valid, 1);
    step();
    f_pl_valid = 1'b1; f_pl_data = 32'h1111_1111; f_pl_last = 1'b0;
    @(negedge clk);
    eq("R3 payload 0", f_out_data, 32'h1111_1111);
    eq("R3 payload 0 last", f_out_last, 0);
    step();
    f_out_ready = 1'b0; f_pl_data = 32'h2222_2222; f_pl_last = 1'b1;
    @(negedge clk);
    eq("R6 pl_ready low", f_pl_ready, 0);
    step();
    f_out_ready = 1'b1;
    @(negedge clk);
    eq("R6 payload 1 kept", f_out_data, 32'h2222_2222);
    eq("R3 payload last", f_out_last, 1);
    step();
    f_pl_valid = 1'b0;
    @(negedge clk);
    eq("R3 back to idle", f_out_valid, 0);
    eq("R3 req ready again", f_req_ready, 1);

    // framer header-only, R4
    f_req_valid = 1'b1; f_req_empty = 1'b1;
    f_req_col = 7'h7F; f_req_row = 5'h1F; f_req_type = 3'd7; f_req_id = 5'h1F;
    f_pl_valid = 1'b1; f_pl_data = 32'hCAFE_0000; f_pl_last = 1'b1;
    step();
    f_req_valid = 1'b0;
    @(negedge clk);
    eq("R4 header word", f_out_data, 32'h8FFF_701F);
    eq("R4 header last", f_out_last, 1);
    eq("R4 no payload taken", f_pl_ready, 0);
    step();
    @(negedge clk);
    eq("R4 done", f_out_valid, 0);
    eq("R4 still no payload", f_pl_ready, 0);
    f_pl_valid = 1'b0;

    // R2 parity clear case
    f_req_valid = 1'b1; f_req_empty = 1'b1;
    f_req_col = 7'd1; f_req_row = 5'd0; f_req_type = 3'd0; f_req_id = 5'd0;
    step();
    f_req_valid = 1'b0;
    @(negedge clk);
    eq("R2 parity zero", f_out_data, 32'h0020_0000);
    chk($countones(f_out_data) % 2 == 1, "R2 odd count", f_out_data, 32'h0020_0000);
    step();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule